// File: doc/BRIEF.md
# Code Bank Return Stack

This block keeps the code bank that instruction fetches use, and keeps it in step with subroutine nesting. Software stages a bank number in a pending register. The stage has no effect until control flow is transferred. A jump pulse then copies the pending bank into the active bank. A call pulse does the same, and first saves the outgoing active bank on a dedicated on-chip stack. A return pulse pops the newest saved bank and makes it active again, so a return always lands in the caller's bank.

The stack runs beside the processor's return-address stack in memory and is separate from it. One stack serves all code. Its pointer wraps at both ends. A debug window lets a monitor read and rewrite any stack entry through the logical page $0100-$01FF while an expose flag is held. The window does not go through the processor's memory.

Top module: `code_bank_stack`

## Requirements
- R1: After reset the active bank, the pending bank and the stack pointer are zero, and every stack entry reads as zero.
- R2: A load pulse copies `load_bank_i` into the pending bank at the next clock edge. It leaves the active bank unchanged when no jump, call or return is asserted.
- R3: A jump pulse makes the active bank equal to the pending bank as it stood before that edge. It leaves the stack pointer and every stack entry unchanged.
- R4: A call pulse writes the current active bank into the entry addressed by the stack pointer. It increments the pointer and makes the pending bank active, all at the same edge.
- R5: A return pulse decrements the stack pointer and makes the entry at the old pointer minus one the active bank. The pending bank is unchanged.
- R6: Nested calls and returns restore the banks in last-in, first-out order.
- R7: Return takes priority over call, and call over jump, when more than one is asserted in the same cycle. A load in the same cycle as a jump or call updates the pending bank, but the transfer uses the old pending value.
- R8: The stack pointer is 8 bits wide and wraps. After 256 calls it is back at its start value. A return at pointer 0 moves it to 255 and activates entry 255.
- R9: While `expose_i` is 1 and `dbg_addr_i[15:8]` is 8'h01, `dbg_hit_o` is 1 and `dbg_rdata_o` shows the entry indexed by `dbg_addr_i[7:0]` in the same cycle. Otherwise `dbg_hit_o` and `dbg_rdata_o` are 0.
- R10: `dbg_we_i` with a window hit writes `dbg_wdata_i` into the addressed entry at the next edge. Without a hit it has no effect. When a call pushes into the same entry in the same cycle, the pushed bank is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load pending bank pulse |
| load_bank_i | input | 8 | Bank value for the pending register |
| jump_i | input | 1 | Jump pulse: activate the pending bank |
| call_i | input | 1 | Call pulse: push the active bank, activate the pending bank |
| ret_i | input | 1 | Return pulse: pop the saved bank into the active bank |
| expose_i | input | 1 | Enables the debug window on the stack |
| dbg_addr_i | input | 16 | Logical debug address |
| dbg_we_i | input | 1 | Debug write strobe |
| dbg_wdata_i | input | 8 | Debug write data |
| dbg_hit_o | output | 1 | Debug address falls in the exposed window |
| dbg_rdata_o | output | 8 | Stack entry selected by the debug address |
| active_bank_o | output | 8 | Active code bank |
| pending_bank_o | output | 8 | Pending code bank |
| stack_ptr_o | output | 8 | Stack pointer, the next free entry |

## Verification
The hardest cases to reach are pointer wrap at both ends and a debug write and a push aimed at one entry in the same cycle. The wrap cases need a full 256-deep run of calls. The stimulus drives a complete lap of calls with distinct pending banks and unwinds it with returns, checking each popped bank. It then drains the pointer to zero and seeds entry 255 through the debug window before a final return. For the collision, a call and a debug write to the current pointer's entry are issued in the same cycle, and the result is read back through the window.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_JUMP, OP_CALL, OP_RET} op_e;

  // return > call > jump
  function automatic op_e pick_op(input logic jump, input logic call, input logic ret);
    if (ret)  return OP_RET;
    if (call) return OP_CALL;
    if (jump) return OP_JUMP;
    return OP_IDLE;
  endfunction
endpackage

// File: rtl/cbs_ptr.sv
module cbs_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] ptr_m1_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (dec_i) ptr_q <= ptr_q - 1'b1;
    else if (inc_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o    = ptr_q;
  assign ptr_m1_o = ptr_q - 1'b1;
endmodule

// File: rtl/cbs_store.sv
module cbs_store #(
  parameter int BANK_W = 8,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [IDX_W-1:0]  push_idx_i,
  input  logic [BANK_W-1:0] push_data_i,
  input  logic              dbg_we_i,
  input  logic [IDX_W-1:0]  dbg_idx_i,
  input  logic [BANK_W-1:0] dbg_data_i,
  input  logic [IDX_W-1:0]  pop_idx_i,
  output logic [BANK_W-1:0] pop_data_o,
  input  logic [IDX_W-1:0]  peek_idx_i,
  output logic [BANK_W-1:0] peek_data_o
);
  logic [DEPTH-1:0][BANK_W-1:0] mem_q;

  // push wins over a debug write to the same entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (push_i && push_idx_i == IDX_W'(e))
          mem_q[e] <= push_data_i;
        else if (dbg_we_i && dbg_idx_i == IDX_W'(e))
          mem_q[e] <= dbg_data_i;
      end
    end
  end

  assign pop_data_o  = mem_q[pop_idx_i];
  assign peek_data_o = mem_q[peek_idx_i];
endmodule

// File: rtl/cbs_bank.sv
module cbs_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BANK_W-1:0] load_bank_i,
  input  logic              take_pending_i,
  input  logic              restore_i,
  input  logic [BANK_W-1:0] restore_bank_i,
  output logic [BANK_W-1:0] active_o,
  output logic [BANK_W-1:0] pending_o
);
  logic [BANK_W-1:0] active_q, pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= '0;
      pending_q <= '0;
    end else begin
      if (load_i) pending_q <= load_bank_i;
      if (restore_i)           active_q <= restore_bank_i;
      else if (take_pending_i) active_q <= pending_q;
    end
  end

  assign active_o  = active_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/code_bank_stack.sv
module code_bank_stack #(
  parameter int          BANK_W   = 8,
  parameter int          DEPTH    = 256,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'h0100,
  localparam int         PTR_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BANK_W-1:0] load_bank_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              expose_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  input  logic              dbg_we_i,
  input  logic [BANK_W-1:0] dbg_wdata_i,
  output logic              dbg_hit_o,
  output logic [BANK_W-1:0] dbg_rdata_o,
  output logic [BANK_W-1:0] active_bank_o,
  output logic [BANK_W-1:0] pending_bank_o,
  output logic [PTR_W-1:0]  stack_ptr_o
);
  import cbs_pkg::*;

  localparam logic [ADDR_W-1:0] WIN_TAG = ADDR_W'(WIN_BASE) >> PTR_W;

  op_e               op;
  logic [PTR_W-1:0]  ptr, ptr_m1, dbg_idx;
  logic [BANK_W-1:0] pop_data, peek_data;
  logic              push;

  assign op      = pick_op(jump_i, call_i, ret_i);
  assign push    = (op == OP_CALL);
  assign dbg_idx = dbg_addr_i[PTR_W-1:0];

  assign dbg_hit_o   = expose_i && ((dbg_addr_i >> PTR_W) == WIN_TAG);
  assign dbg_rdata_o = dbg_hit_o ? peek_data : '0;

  cbs_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (push),
    .dec_i   (op == OP_RET),
    .ptr_o   (ptr),
    .ptr_m1_o(ptr_m1)
  );

  cbs_store #(.BANK_W(BANK_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_idx_i (ptr),
    .push_data_i(active_bank_o),
    .dbg_we_i   (dbg_we_i && dbg_hit_o),
    .dbg_idx_i  (dbg_idx),
    .dbg_data_i (dbg_wdata_i),
    .pop_idx_i  (ptr_m1),
    .pop_data_o (pop_data),
    .peek_idx_i (dbg_idx),
    .peek_data_o(peek_data)
  );

  cbs_bank #(.BANK_W(BANK_W)) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load_i),
    .load_bank_i   (load_bank_i),
    .take_pending_i(op == OP_JUMP || op == OP_CALL),
    .restore_i     (op == OP_RET),
    .restore_bank_i(pop_data),
    .active_o      (active_bank_o),
    .pending_o     (pending_bank_o)
  );

  assign stack_ptr_o = ptr;
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int BANK_W = 8,
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [BANK_W-1:0] load_bank_i,
  input logic              jump_i,
  input logic              call_i,
  input logic              ret_i,
  input logic [BANK_W-1:0] active_bank_o,
  input logic [BANK_W-1:0] pending_bank_o,
  input logic [PTR_W-1:0]  stack_ptr_o
);
  p_load_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pending_bank_o == $past(load_bank_i));

  p_load_keeps_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !jump_i && !call_i && !ret_i) |=> $stable(active_bank_o));

  p_jump_activates_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !call_i && !ret_i) |=>
      (active_bank_o == $past(pending_bank_o)) && $stable(stack_ptr_o));

  p_call_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i) |=>
      (stack_ptr_o == PTR_W'($past(stack_ptr_o) + 1'b1)) &&
      (active_bank_o == $past(pending_bank_o)));

  p_ret_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> (stack_ptr_o == PTR_W'($past(stack_ptr_o) - 1'b1)) && $stable(pending_bank_o));

  p_idle_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_i && !ret_i) |=> $stable(stack_ptr_o));
endmodule

bind code_bank_stack cbs_checker #(.BANK_W(BANK_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .load_i        (load_i),
  .load_bank_i   (load_bank_i),
  .jump_i        (jump_i),
  .call_i        (call_i),
  .ret_i         (ret_i),
  .active_bank_o (active_bank_o),
  .pending_bank_o(pending_bank_o),
  .stack_ptr_o   (stack_ptr_o)
);

// File: tb/sim_code_bank_stack.sv
`timescale 1ns/1ps
module sim_code_bank_stack;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 0, jump_i = 0, call_i = 0, ret_i = 0, expose_i = 0, dbg_we_i = 0;
  logic [7:0]  load_bank_i = '0, dbg_wdata_i = '0;
  logic [15:0] dbg_addr_i = '0;
  logic        dbg_hit_o;
  logic [7:0]  dbg_rdata_o, active_bank_o, pending_bank_o, stack_ptr_o;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] act, pend, sp;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] m_mem [256];
  logic [7:0] m_act = '0, m_pend = '0, m_sp = '0;

  always #5 clk = ~clk;

  code_bank_stack u0 (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .load_bank_i(load_bank_i),
    .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i), .expose_i(expose_i),
    .dbg_addr_i(dbg_addr_i), .dbg_we_i(dbg_we_i), .dbg_wdata_i(dbg_wdata_i),
    .dbg_hit_o(dbg_hit_o), .dbg_rdata_o(dbg_rdata_o), .active_bank_o(active_bank_o),
    .pending_bank_o(pending_bank_o), .stack_ptr_o(stack_ptr_o)
  );

  // driver: apply one cycle of stimulus and queue the expected post-edge state
  task automatic step(input logic ld, input logic [7:0] lb, input logic j, input logic c,
                      input logic r, input logic we, input logic ex, input logic [15:0] a,
                      input logic [7:0] wd, input string tag);
    logic [7:0] n_act, n_sp, pm1;
    logic       hit, push;
    exp_t       e;
    @(negedge clk);
    load_i = ld; load_bank_i = lb; jump_i = j; call_i = c; ret_i = r;
    dbg_we_i = we; expose_i = ex; dbg_addr_i = a; dbg_wdata_i = wd;
    hit  = ex && (a[15:8] == 8'h01);
    push = c && !r;
    pm1  = m_sp - 8'd1;
    n_act = m_act; n_sp = m_sp;
    if (r)      begin n_sp = pm1;          n_act = m_mem[pm1]; end
    else if (c) begin n_sp = m_sp + 8'd1;  n_act = m_pend;     end
    else if (j) n_act = m_pend;
    if (we && hit && !(push && a[7:0] == m_sp)) m_mem[a[7:0]] = wd;
    if (push) m_mem[m_sp] = m_act;
    if (ld) m_pend = lb;
    m_act = n_act; m_sp = n_sp;
    e.act = m_act; e.pend = m_pend; e.sp = m_sp; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare after every edge that has a queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (active_bank_o !== e.act || pending_bank_o !== e.pend || stack_ptr_o !== e.sp) begin
          failures++;
          $display("FAIL %s act/pend/sp=%h/%h/%h expected %h/%h/%h", e.tag,
                   active_bank_o, pending_bank_o, stack_ptr_o, e.act, e.pend, e.sp);
        end
      end
    end
  end

  // combinational debug window check, no state change
  task automatic peek(input logic ex, input logic [15:0] a, input string tag);
    logic       eh;
    logic [7:0] ed;
    @(negedge clk);
    load_i = 0; jump_i = 0; call_i = 0; ret_i = 0; dbg_we_i = 0;
    expose_i = ex; dbg_addr_i = a;
    #1;
    eh = ex && (a[15:8] == 8'h01);
    ed = eh ? m_mem[a[7:0]] : 8'h00;
    checks++;
    if (dbg_hit_o !== eh || dbg_rdata_o !== ed) begin
      failures++;
      $display("FAIL %s addr=%h hit/data=%b/%h expected %b/%h", tag, a, dbg_hit_o, dbg_rdata_o, eh, ed);
    end
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 0, 0, 0, 16'h0000, 8'h00, "idle");
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (active_bank_o !== 8'h00 || pending_bank_o !== 8'h00 || stack_ptr_o !== 8'h00) begin
      failures++;
      $display("FAIL R1 act/pend/sp=%h/%h/%h expected 00/00/00", active_bank_o, pending_bank_o, stack_ptr_o);
    end
    peek(1, 16'h0100, "R1 entry 00 clear");
    peek(1, 16'h01FF, "R1 entry ff clear");

    step(1, 8'h12, 0, 0, 0, 0, 0, 16'h0, 8'h0, "R2 load keeps active");
    step(0, 8'h00, 1, 0, 0, 0, 0, 16'h0, 8'h0, "R3 jump");
    step(1, 8'h34, 0, 0, 0, 0, 0, 16'h0, 8'h0, "R2 load");
    step(0, 8'h00, 0, 1, 0, 0, 0, 16'h0, 8'h0, "R4 call");
    peek(1, 16'h0100, "R4 pushed bank visible R9");
    step(1, 8'h56, 0, 0, 0, 0, 0, 16'h0, 8'h0, "R2 load");
    step(0, 8'h00, 0, 1, 0, 0, 0, 16'h0, 8'h0, "R6 call 2");
    step(1, 8'h78, 0, 1, 0, 0, 0, 16'h0, 8'h0, "R7 load with call uses old pending");
    step(0, 8'h00, 0, 0, 1, 0, 0, 16'h0, 8'h0, "R5 R6 ret 1");
    step(0, 8'h00, 0, 0, 1, 0, 0, 16'h0, 8'h0, "R6 ret 2");
    step(0, 8'h00, 0, 0, 1, 0, 0, 16'h0, 8'h0, "R6 ret 3");
    step(1, 8'h9A, 1, 0, 0, 0, 0, 16'h0, 8'h0, "R7 load with jump");
    step(0, 8'h00, 1, 1, 0, 0, 0, 16'h0, 8'h0, "R7 call over jump");
    step(0, 8'h00, 0, 1, 1, 0, 0, 16'h0, 8'h0, "R7 ret over call");
    step(0, 8'h00, 1, 1, 1, 0, 0, 16'h0, 8'h0, "R7 ret over all");

    // R9 window decode
    peek(0, 16'h0100, "R9 expose off");
    peek(1, 16'h0200, "R9 outside page");
    peek(1, 16'h0000, "R9 below page");

    // R10 debug writes
    step(0, 8'h00, 0, 0, 0, 1, 1, 16'h0105, 8'hC3, "R10 write hit");
    peek(1, 16'h0105, "R10 readback");
    step(0, 8'h00, 0, 0, 0, 1, 0, 16'h0106, 8'hEE, "R10 write no expose");
    peek(1, 16'h0106, "R10 no-expose ignored");
    step(0, 8'h00, 0, 0, 0, 1, 1, 16'h0206, 8'hEE, "R10 write off page");
    peek(1, 16'h0106, "R10 off-page ignored");
    // write then pop it
    step(0, 8'h00, 0, 0, 0, 1, 1, {8'h01, m_sp - 8'd1}, 8'h4D, "R10 overwrite top");
    step(0, 8'h00, 0, 0, 1, 0, 0, 16'h0, 8'h0, "R10 R5 pop rewritten entry");
    // collision: push and debug write to same entry
    step(1, 8'h61, 0, 0, 0, 0, 0, 16'h0, 8'h0, "R2 load");
    step(0, 8'h00, 0, 1, 0, 1, 1, {8'h01, m_sp}, 8'hBB, "R10 push wins collision");
    peek(1, {8'h01, m_sp - 8'd1}, "R10 collision readback");

    // R8 full lap
    for (int i = 0; i < 256; i++)
      step(1, 8'(i) ^ 8'h5A, 0, 1, 0, 0, 0, 16'h0, 8'h0, "R8 lap call");
    for (int i = 0; i < 256; i++)
      step(0, 8'h00, 0, 0, 1, 0, 0, 16'h0, 8'h0, "R8 lap ret");
    while (m_sp != 8'h00)
      step(0, 8'h00, 0, 0, 1, 0, 0, 16'h0, 8'h0, "R8 drain");
    step(0, 8'h00, 0, 0, 0, 1, 1, 16'h01FF, 8'hA5, "R10 seed ff");
    step(0, 8'h00, 0, 0, 1, 0, 0, 16'h0, 8'h0, "R8 underflow wrap");
    peek(1, 16'h01FF, "R9 entry ff");
    idle();
    @(posedge clk);
    #2;
    finish_run();
  end
endmodule